// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block walks a rectangular memory pattern and issues one address per element through a valid/ready handshake. A transfer is described by a base address, a row length with its per-element step, and a row count with a row-end step. The row-end step is applied in place of the element step on the last element of every row. This lets the row stride be written as the distance from the end of one row to the start of the next. The same engine serves a continuous refresh read of a whole framebuffer, where both steps equal the word size, and a copy into a sub-rectangle of a framebuffer, where the row-end step skips the part of each line outside the rectangle.

Software sets the configuration inputs and pulses `start` while the block is idle. The block latches the configuration and raises `busy` and `addr_valid`. It advances on each accepted address. In one-shot mode it pulses `done` after the final element. In wrap mode it returns to the base and begins again without a new strobe. A zero row length or row count sets `cfg_err` and no addresses are issued. From the fill level of the consumer's FIFO, the block derives a request output and an urgent-priority output for the memory arbiter.

Top module: `dma2d_addr_gen`

## Requirements
- R1: Within a row, each accepted address other than the row's last is followed by that address plus the sign-extended `cfg_step` (two's complement).
- R2: After the last element of a row that is not the final row is accepted, the next address is that address plus the sign-extended `cfg_skip`, and the row count starts over.
- R3: When `start` is sampled high while idle with both counts nonzero, then in the next cycle `busy` and `addr_valid` are high and `addr` equals `cfg_base`.
- R4: While `addr_valid` is high and `addr_ready` is low, `addr` and `addr_valid` keep their values in the next cycle.
- R5: In one-shot mode (`cfg_wrap`=0), in the cycle after the final element is accepted, `busy` and `addr_valid` are low and `done` is high for exactly that one cycle.
- R6: In wrap mode (`cfg_wrap`=1), the address after the final element is `cfg_base` again. `busy` stays high and `done` stays low.
- R7: A start while idle with `cfg_row_len`=0 or `cfg_rows`=0 sets `cfg_err` and leaves `addr_valid` low. The next valid start clears `cfg_err`.
- R8: A `start` pulse while busy is ignored, and configuration inputs that change during a transfer do not alter its address sequence.
- R9: `req` is high exactly when `busy` is high and `fifo_fill` is below `FIFO_DEPTH`.
- R10: `req_urgent` is high exactly when `busy` is high and `fifo_fill` is at or below `FIFO_DEPTH*3/4`.
- R11: During and right after reset, `busy`, `addr_valid`, `done`, `cfg_err`, `req` and `req_urgent` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | First address of the pattern |
| cfg_row_len | input | CNT_W | Elements per row |
| cfg_step | input | INC_W | Signed step between elements of a row |
| cfg_rows | input | CNT_W | Number of rows |
| cfg_skip | input | INC_W | Signed step applied after the last element of a row |
| cfg_wrap | input | 1 | Restart from the base after the final element |
| start | input | 1 | Launch strobe, honoured only while idle |
| addr | output | ADDR_W | Current element address |
| addr_valid | output | 1 | Address is offered |
| addr_ready | input | 1 | Consumer accepts the address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after a one-shot transfer ends |
| cfg_err | output | 1 | Last start attempt had a zero count |
| fifo_fill | input | LVL_W | Occupied entries in the consumer FIFO |
| req | output | 1 | Normal memory request |
| req_urgent | output | 1 | Raised priority request |

## Verification
The bench builds the block with 8-bit counts, 16-bit signed steps and a FIFO depth of 8. Short rows and a few rows then reach every row-boundary and end-of-pattern transition within a few dozen cycles each. Depth 8 puts the urgent threshold at 6, so the full, just-below-full and threshold fill levels can all be driven directly. The vectors cover a scaled-down framebuffer refresh, a 16-bit rectangle copy into a ten-pixel-wide 24-bit screen with its even-column rule, negative steps and a single-element pattern.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/dma2d_seq.sv
module dma2d_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] row_len,
  input  logic [CNT_W-1:0] rows,
  input  logic             wrap,
  input  logic             ready,
  output logic             launch,
  output logic             rewind,
  output logic             step_in,
  output logic             step_out,
  output logic             busy,
  output logic             done,
  output logic             err
);
  import dma2d_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] len_q, rows_q;
  logic [CNT_W-1:0] x_q, x_d, y_q, y_d;
  logic             wrap_q;
  logic             err_q, err_d;
  logic             done_q, done_d;
  logic             idle, zero_cfg, bad_start, fire, row_end, last_elem, finish;
  logic             cnt_en;

  always_comb begin
    idle      = (st_q == ST_IDLE);
    zero_cfg  = (row_len == '0) || (rows == '0);
    launch    = idle && start && !zero_cfg;
    bad_start = idle && start && zero_cfg;
    fire      = (st_q == ST_RUN) && ready;
    row_end   = (x_q == ONE);
    last_elem = row_end && (y_q == ONE);
    rewind    = fire && last_elem && wrap_q;
    finish    = fire && last_elem && !wrap_q;
    step_out  = fire && row_end && !last_elem;
    step_in   = fire && !row_end;
    cnt_en    = launch || fire;
  end

  always_comb begin
    st_d = st_q;
    if (launch)      st_d = ST_RUN;
    else if (finish) st_d = ST_IDLE;

    x_d = x_q;
    y_d = y_q;
    if (launch) begin
      x_d = row_len;
      y_d = rows;
    end else if (rewind) begin
      x_d = len_q;
      y_d = rows_q;
    end else if (step_out) begin
      x_d = len_q;
      y_d = y_q - ONE;
    end else if (step_in) begin
      x_d = x_q - ONE;
    end

    err_d = err_q;
    if (bad_start)   err_d = 1'b1;
    else if (launch) err_d = 1'b0;

    done_d = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      rows_q <= '0;
      wrap_q <= 1'b0;
    end else if (launch) begin
      len_q  <= row_len;
      rows_q <= rows;
      wrap_q <= wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (cnt_en) begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign busy = (st_q == ST_RUN);
  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/dma2d_addr.sv
module dma2d_addr #(
  parameter int ADDR_W = 32,
  parameter int INC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic [INC_W-1:0]  step,
  input  logic [INC_W-1:0]  skip,
  input  logic              launch,
  input  logic              rewind,
  input  logic              step_in,
  input  logic              step_out,
  output logic [ADDR_W-1:0] addr
);
  localparam int EXT_W = ADDR_W - INC_W;

  logic [ADDR_W-1:0] base_q, a_q, a_d;
  logic [INC_W-1:0]  step_q, skip_q;
  logic [ADDR_W-1:0] step_x, skip_x;
  logic              a_en;

  always_comb begin
    step_x = {{EXT_W{step_q[INC_W-1]}}, step_q};
    skip_x = {{EXT_W{skip_q[INC_W-1]}}, skip_q};
    a_en   = launch || rewind || step_in || step_out;
    a_d    = a_q;
    if (launch)        a_d = base;
    else if (rewind)   a_d = base_q;
    else if (step_out) a_d = a_q + skip_x;
    else if (step_in)  a_d = a_q + step_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      skip_q <= '0;
    end else if (launch) begin
      base_q <= base;
      step_q <= step;
      skip_q <= skip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    a_q <= '0;
    else if (a_en) a_q <= a_d;
  end

  assign addr = a_q;
endmodule

// File: rtl/dma2d_prio.sv
module dma2d_prio #(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             busy,
  input  logic [LVL_W-1:0] fill,
  output logic             req,
  output logic             urgent
);
  localparam int               URG_INT  = (FIFO_DEPTH * 3) / 4;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);
  localparam logic [LVL_W-1:0] URG_LVL  = LVL_W'(URG_INT);

  always_comb begin
    req    = busy && (fill < FULL_LVL);
    urgent = busy && (fill <= URG_LVL);
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int INC_W      = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_row_len,
  input  logic [INC_W-1:0]  cfg_step,
  input  logic [CNT_W-1:0]  cfg_rows,
  input  logic [INC_W-1:0]  cfg_skip,
  input  logic              cfg_wrap,
  input  logic              start,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic              busy,
  output logic              done,
  output logic              cfg_err,
  input  logic [LVL_W-1:0]  fifo_fill,
  output logic              req,
  output logic              req_urgent
);
  logic launch, rewind, step_in, step_out, busy_i;

  dma2d_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .row_len  (cfg_row_len),
    .rows     (cfg_rows),
    .wrap     (cfg_wrap),
    .ready    (addr_ready),
    .launch   (launch),
    .rewind   (rewind),
    .step_in  (step_in),
    .step_out (step_out),
    .busy     (busy_i),
    .done     (done),
    .err      (cfg_err)
  );

  dma2d_addr #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .base     (cfg_base),
    .step     (cfg_step),
    .skip     (cfg_skip),
    .launch   (launch),
    .rewind   (rewind),
    .step_in  (step_in),
    .step_out (step_out),
    .addr     (addr)
  );

  dma2d_prio #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_prio (
    .busy   (busy_i),
    .fill   (fifo_fill),
    .req    (req),
    .urgent (req_urgent)
  );

  assign busy       = busy_i;
  assign addr_valid = busy_i;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic              busy,
  input logic              done,
  input logic              cfg_err,
  input logic              req,
  input logic              req_urgent
);
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr)));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !addr_valid));

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !addr_valid);

  // R10
  urgent_implies_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_urgent |-> req);

  // R9
  req_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> busy);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .addr_valid (addr_valid),
  .addr_ready (addr_ready),
  .busy       (busy),
  .done       (done),
  .cfg_err    (cfg_err),
  .req        (req),
  .req_urgent (req_urgent)
);

// File: tb/sim_dma2d_addr_gen.sv
module sim_dma2d_addr_gen;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 8;
  localparam int INC_W  = 16;
  localparam int DEPTH  = 8;
  localparam int LVL_W  = $clog2(DEPTH + 1);
  localparam int NVEC   = 4;

  // vectors: base, row length, step, rows, skip
  localparam logic [31:0] V_BASE [NVEC] = '{32'h0000_0100, 32'h0000_1048, 32'h0000_0800, 32'h0000_0040};
  localparam int          V_LEN  [NVEC] = '{6, 6, 3, 1};
  localparam logic [15:0] V_STEP [NVEC] = '{16'd4, 16'd2, 16'hFFFC, 16'd4};
  localparam int          V_ROWS [NVEC] = '{3, 3, 2, 1};
  localparam logic [15:0] V_SKIP [NVEC] = '{16'd4, 16'd20, 16'hFFF8, 16'd4};

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] cfg_base;
  logic [CNT_W-1:0]  cfg_row_len, cfg_rows;
  logic [INC_W-1:0]  cfg_step, cfg_skip;
  logic              cfg_wrap, start, addr_ready;
  logic [LVL_W-1:0]  fifo_fill;
  logic [ADDR_W-1:0] addr;
  logic              addr_valid, busy, done, cfg_err, req, req_urgent;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma2d_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .INC_W(INC_W), .FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_row_len(cfg_row_len),
    .cfg_step(cfg_step), .cfg_rows(cfg_rows), .cfg_skip(cfg_skip), .cfg_wrap(cfg_wrap),
    .start(start), .addr(addr), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .busy(busy), .done(done), .cfg_err(cfg_err), .fifo_fill(fifo_fill),
    .req(req), .req_urgent(req_urgent)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_vec(input int v);
    logic [31:0] exp_a, hold_a;
    int n, total, xi, yi;
    bit held;
    cfg_base    = V_BASE[v];
    cfg_row_len = CNT_W'(V_LEN[v]);
    cfg_step    = V_STEP[v];
    cfg_rows    = CNT_W'(V_ROWS[v]);
    cfg_skip    = V_SKIP[v];
    cfg_wrap    = 1'b0;
    addr_ready  = 1'b1;
    pulse_start();
    // R3: launch visible one cycle after start is sampled
    chk(busy && addr_valid && addr == V_BASE[v], "R3", addr, V_BASE[v]);
    total = V_LEN[v] * V_ROWS[v];
    exp_a = V_BASE[v];
    n = 0; xi = 0; yi = 0; held = 1'b0;
    while (n < total) begin
      start = 1'b0;
      if ((n % 3 == 1) && !held) begin
        addr_ready = 1'b0;
        hold_a = addr;
        held = 1'b1;
        @(negedge clk);
        // R4: stall keeps the address
        chk(addr_valid && addr == hold_a, "R4", addr, hold_a);
      end else begin
        addr_ready = 1'b1;
        if (xi == 0 && yi > 0) chk(addr_valid && addr == exp_a, "R2", addr, exp_a);
        else                   chk(addr_valid && addr == exp_a, "R1", addr, exp_a);
        if (v == 0 && n == 2) begin
          // R8: start and new configuration while busy
          start       = 1'b1;
          cfg_base    = 32'hDEAD_0000;
          cfg_row_len = 8'd1;
          cfg_rows    = 8'd1;
          cfg_step    = 16'd100;
          cfg_skip    = 16'd100;
        end
        if (xi == V_LEN[v] - 1) begin
          exp_a = exp_a + sx(V_SKIP[v]);
          xi = 0;
          yi++;
        end else begin
          exp_a = exp_a + sx(V_STEP[v]);
          xi++;
        end
        n++;
        held = 1'b0;
        @(negedge clk);
        if (v == 0 && n == 3)
          chk(addr == V_BASE[0] + 32'd12, "R8", addr, V_BASE[0] + 32'd12);
      end
    end
    start = 1'b0;
    addr_ready = 1'b0;
    chk(done && !busy && !addr_valid, "R5", {29'd0, done, busy, addr_valid}, 32'h4);
    @(negedge clk);
    chk(!done, "R5", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] wexp [4];
    rst_n = 1'b0;
    cfg_base = '0; cfg_row_len = '0; cfg_step = '0; cfg_rows = '0; cfg_skip = '0;
    cfg_wrap = 1'b0; start = 1'b0; addr_ready = 1'b0; fifo_fill = '0;
    repeat (3) @(negedge clk);
    // R11: outputs quiet in reset
    chk(!busy && !addr_valid && !done && !cfg_err && !req && !req_urgent, "R11",
        {26'd0, busy, addr_valid, done, cfg_err, req, req_urgent}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !addr_valid && !done && !cfg_err && !req && !req_urgent, "R11",
        {26'd0, busy, addr_valid, done, cfg_err, req, req_urgent}, 32'd0);

    for (int v = 0; v < NVEC; v++) run_vec(v);

    // R7: zero row length
    cfg_row_len = 8'd0; cfg_rows = 8'd3;
    pulse_start();
    chk(cfg_err && !addr_valid && !busy, "R7", {29'd0, cfg_err, addr_valid, busy}, 32'h4);
    @(negedge clk);
    chk(cfg_err && !addr_valid, "R7", {30'd0, cfg_err, addr_valid}, 32'h2);
    // R7: zero row count
    cfg_row_len = 8'd2; cfg_rows = 8'd0;
    pulse_start();
    chk(cfg_err && !addr_valid, "R7", {30'd0, cfg_err, addr_valid}, 32'h2);
    run_vec(3);
    chk(!cfg_err, "R7", {31'd0, cfg_err}, 32'd0);

    // R6: wrap mode returns to base
    wexp = '{32'h200, 32'h204, 32'h20C, 32'h210};
    cfg_base = 32'h200; cfg_row_len = 8'd2; cfg_step = 16'd4;
    cfg_rows = 8'd2; cfg_skip = 16'd8; cfg_wrap = 1'b1;
    addr_ready = 1'b1;
    pulse_start();
    for (int k = 0; k < 9; k++) begin
      chk(addr == wexp[k % 4] && busy && !done, "R6", addr, wexp[k % 4]);
      @(negedge clk);
    end
    addr_ready = 1'b0;
    @(negedge clk);

    // R9 / R10: priority outputs while busy
    fifo_fill = LVL_W'(8); #1;
    chk(!req && !req_urgent, "R9", {30'd0, req, req_urgent}, 32'd0);
    fifo_fill = LVL_W'(7); #1;
    chk(req && !req_urgent, "R9", {30'd0, req, req_urgent}, 32'h2);
    fifo_fill = LVL_W'(6); #1;
    chk(req && req_urgent, "R10", {30'd0, req, req_urgent}, 32'h3);
    fifo_fill = LVL_W'(0); #1;
    chk(req && req_urgent, "R10", {30'd0, req, req_urgent}, 32'h3);

    // R11: reset ends wrap mode and clears outputs
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk(!busy && !addr_valid && !req && !req_urgent, "R11",
        {28'd0, busy, addr_valid, req, req_urgent}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule